// File: doc/BRIEF.md
# Pipelined Single-Gate Pulse Counter

This block counts pulses on a one-bit enable input. It is meant for wide counters on fabrics that have no fast carry chain. It is a row of identical divide-by-two stages. Each stage holds a toggle flip-flop and, except for the last stage, one registered carry flip-flop. At most one gate (an AND or a 2:1 select) sits between any two flip-flops, so the clock rate does not depend on the width.

A carry moves up by one stage per clock, as a pulse one clock wide. As a result, bit k of the output follows the true pulse total with a lag of exactly k clocks. The raw word is therefore not a monotonic binary count while carries are in flight. After N-1 clocks with no new pulse, the word settles to the true total modulo 2^N. A separate decoder turns the raw word into a linear count; that decoder is outside this block.

Top module: `pipe_pulse_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, every toggle bit and every in-flight carry is cleared. After reset, `raw_q` reads 0 and stays 0 until a pulse is accepted.
- R2: Bit 0 of `raw_q` inverts after every rising edge at which `count_en` is 1. It holds its value after every edge at which `count_en` is 0.
- R3: After rising edge t, bit k of `raw_q` equals bit k of the number of pulses accepted up to and including edge t-k. Pulses before the last reset do not count, and edges before that reset count as zero pulses.
- R4: Bit k (k ≥ 1) changes at an edge if and only if bit k-1 went from 1 to 0 at the edge just before it.
- R5: Each internal carry is high for one clock at most. It is never high in two consecutive cycles.
- R6: After N-1 or more edges with `count_en` low, `raw_q` equals the number of accepted pulses modulo 2^N, read as plain binary.
- R7: When the settled word is all ones, one more pulse clears the bits one stage per clock, lowest bit first. Once settled, the word reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_en | input | 1 | Count pulse; one count for each rising edge at which it is high |
| raw_q | output | N | Raw state word; bit k lags the true count by k clocks |

## Verification
Two things can land on the same edge. A new pulse can toggle bit 0 while carries from earlier pulses are still travelling through the upper stages. A reset can also arrive while such carries are in flight. The bench causes the first case with long runs of back-to-back pulses through a full wrap, and with sparse patterns. It judges every cycle against a history of pulse totals, taking bit k from the total k edges back. For the second case, the bench drives an all-ones word into a full ripple and resets it midway. It then requires the word to stay at zero through more than N idle clocks, which shows that no stale carry survived.

// File: rtl/pcnt_pkg.sv
// Package: pcnt_pkg
// Shared constants for the pipelined pulse counter.
// Assumes nothing beyond being compiled ahead of the counter modules.
package pcnt_pkg;
    // The smallest width the chain supports; one stage has no carry to forward.
    localparam int unsigned PCNT_MIN_WIDTH = 2;
endpackage

// File: rtl/pcnt_toggle_stage.sv
// Module: pcnt_toggle_stage
// Holds one bit of the counter and inverts it when its incoming pulse is high.
// Assumes pulse_i is a registered signal or a primary input (one gate of depth).
module pcnt_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    output logic bit_o
);
    logic bit_q;

    // Toggle the stored bit on an incoming pulse; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
        end else if (pulse_i) begin
            bit_q <= ~bit_q;
        end
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/pcnt_carry_stage.sv
// Module: pcnt_carry_stage
// Registers the carry that the next stage receives. It fires when the local
// bit is 1 and a pulse arrives, which is the 1-to-0 step of that bit.
// Assumes bit_i is the current (pre-edge) value of the matching toggle stage.
module pcnt_carry_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic bit_i,
    output logic carry_o
);
    logic carry_q;

    // Capture a single-clock carry pulse; flush it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else begin
            carry_q <= pulse_i & bit_i;
        end
    end

    assign carry_o = carry_q;
endmodule

// File: rtl/pipe_pulse_counter.sv
// Module: pipe_pulse_counter
// A chain of N divide-by-two stages with one registered carry between
// neighbours. Bit k lags the true count by k clocks; the raw word is exposed.
// Assumes N >= 2 and that count_en is synchronous to clk.
module pipe_pulse_counter #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    output logic [N-1:0] raw_q
);
    import pcnt_pkg::*;

    localparam int unsigned NUM_CARRY = N - 1;

    logic [N-1:0]         stage_pulse;
    logic [NUM_CARRY-1:0] carry_q;

    // Stage 0 is driven by the external enable; each higher stage takes the
    // registered carry of the stage below it.
    assign stage_pulse[0] = count_en;

    if (N < PCNT_MIN_WIDTH) begin : g_width_check
        $error("pipe_pulse_counter: N must be at least 2");
    end

    for (genvar i = 0; i < N; i++) begin : g_stage
        pcnt_toggle_stage u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (stage_pulse[i]),
            .bit_o   (raw_q[i])
        );

        if (i < NUM_CARRY) begin : g_carry
            pcnt_carry_stage u_carry (
                .clk     (clk),
                .rst_n   (rst_n),
                .pulse_i (stage_pulse[i]),
                .bit_i   (raw_q[i]),
                .carry_o (carry_q[i])
            );
            assign stage_pulse[i+1] = carry_q[i];
        end
    end
endmodule

// File: rtl/pcnt_checker.sv
// Module: pcnt_checker
// Temporal checks for pipe_pulse_counter, attached through bind below.
// Assumes carry_q is the counter's internal carry register row.
module pcnt_checker #(
    parameter int unsigned N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         count_en,
    input logic [N-1:0] raw_q,
    input logic [N-2:0] carry_q
);
    logic [1:0] armed;

    // Count edges since reset so that $past never reaches before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 2'd0;
        end else if (armed != 2'd3) begin
            armed <= armed + 2'd1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (raw_q == '0) && (carry_q == '0));

    assert_bit0_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed != 2'd0) && count_en |=> raw_q[0] != $past(raw_q[0]));

    assert_bit0_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed != 2'd0) && !count_en |=> raw_q[0] == $past(raw_q[0]));

    for (genvar k = 1; k < N; k++) begin : g_ripple
        assert_ripple_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (armed >= 2'd2) |->
            ((raw_q[k] != $past(raw_q[k])) ==
             ($past(raw_q[k-1], 2) && !$past(raw_q[k-1]))));
    end

    for (genvar c = 0; c < N - 1; c++) begin : g_carry_width
        assert_carry_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
            carry_q[c] |=> !carry_q[c]);
    end
endmodule

bind pipe_pulse_counter pcnt_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (count_en),
    .raw_q    (raw_q),
    .carry_q  (carry_q)
);

// File: tb/pipe_pulse_counter_tb.sv
// Bench: directed scenarios, each task checking its own results against a
// history of pulse totals (bit k taken from the total k edges back).
module pipe_pulse_counter_tb;
    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         count_en = 1'b0;
    logic [N-1:0] raw_q;

    int n_tests = 0;
    int n_fail  = 0;

    logic [N-1:0] total;
    logic [N-1:0] hist [N];

    pipe_pulse_counter #(.N(N)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .raw_q    (raw_q)
    );

    always #2 clk = ~clk;

    // Reference: pulse total after each edge, kept for the last N edges.
    always @(posedge clk) begin
        logic [N-1:0] nxt;
        if (!rst_n) begin
            total <= '0;
            for (int i = 0; i < N; i++) hist[i] <= '0;
        end else begin
            nxt = total + N'(count_en);
            total <= nxt;
            hist[0] <= nxt;
            for (int i = 1; i < N; i++) hist[i] <= hist[i-1];
        end
    end

    task automatic check_eq(input string req, input logic [N-1:0] act,
                            input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: raw_q=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] lag_expect();
        logic [N-1:0] e;
        for (int k = 0; k < N; k++) e[k] = hist[k][k];
        return e;
    endfunction

    // Check the previous edge's result, then drive the enable for the next one.
    task automatic cycle(input logic en, input string req);
        @(negedge clk);
        check_eq(req, raw_q, lag_expect());
        count_en = en;
    endtask

    task automatic settle(input string req);
        for (int i = 0; i < N + 1; i++) cycle(1'b0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        count_en = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1 during reset", raw_q, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            check_eq("R1 idle after reset", raw_q, '0);
        end
    endtask

    task automatic t_single();
        do_reset();
        cycle(1'b1, "R2 single");
        for (int i = 0; i < N + 2; i++) cycle(1'b0, "R3 single lag");
        @(negedge clk);
        check_eq("R6 single settled", raw_q, N'(1));
    endtask

    task automatic t_continuous();
        do_reset();
        for (int i = 0; i < (1 << N) + 20; i++) cycle(1'b1, "R3 continuous");
        settle("R3 continuous drain");
        @(negedge clk);
        check_eq("R6 continuous settled", raw_q, N'(20));
    endtask

    task automatic t_sparse();
        int cnt = 0;
        do_reset();
        for (int i = 0; i < 90; i++) begin
            cycle((i % 3) == 0, "R3 sparse");
            if ((i % 3) == 0) cnt++;
        end
        settle("R3 sparse drain");
        @(negedge clk);
        check_eq("R6 sparse settled", raw_q, N'(cnt));
    endtask

    task automatic t_idle_hold();
        logic [N-1:0] held;
        @(negedge clk);
        count_en = 1'b0;
        held = raw_q;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check_eq("R2 hold without enable", raw_q, held);
        end
    endtask

    task automatic fill_ones();
        do_reset();
        for (int i = 0; i < (1 << N) - 1; i++) cycle(1'b1, "R3 fill");
        settle("R3 fill drain");
        @(negedge clk);
        check_eq("R6 all ones", raw_q, '1);
    endtask

    task automatic t_wrap_ripple();
        logic [N-1:0] ones = '1;
        fill_ones();
        count_en = 1'b1;
        @(negedge clk);
        count_en = 1'b0;
        for (int j = 0; j < N; j++) begin
            check_eq("R4 R5 ripple step", raw_q, ones << (j + 1));
            @(negedge clk);
        end
        check_eq("R7 wrap to zero", raw_q, '0);
    endtask

    task automatic t_reset_midflight();
        fill_ones();
        count_en = 1'b1;
        @(negedge clk);
        count_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_eq("R1 reset mid ripple", raw_q, '0);
        for (int i = 0; i < N + 2; i++) begin
            @(negedge clk);
            check_eq("R1 no stale carry", raw_q, '0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_continuous();
        t_idle_hold();
        t_sparse();
        t_wrap_ripple();
        t_reset_midflight();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule